// File: doc/BRIEF.md
# Bounded Circular Command FIFO

This block is the queue of one channel, held in a region of a shared 512-word storage array. Two 9-bit bounds, a first entry and a last entry, mark the region. Both bounds are inclusive. A read pointer and a write pointer move inside that region. When a pointer is at the last entry, its next step takes it back to the first entry. At any other entry it moves up by one. The queue holds data whenever the two pointers differ. One slot is always left unused, so a region of N entries stores at most N-1 words.

Words go in through a push port and come out through a pop port. The popped word appears one cycle after the pop is accepted. A separate peek port reads the word at any chosen pointer and leaves the queue as it is, so debug logic can walk the live entries from the read pointer up to the write pointer. A peek carries a channel select, and only a peek aimed at this block's channel number returns data. Both pointers are also available together on one 32-bit status word.

Top module: `cfifo_bounded`

## Requirements
- R1: While `rst_n` is low, both pointers load `cfg_start`. After reset, `empty` is 1, `full` is 0 and `pop_valid` and `peek_valid` are 0.
- R2: A pointer that advances from `cfg_end` takes the value `cfg_start`. From any other value it increments by one.
- R3: An accepted push writes `push_data` at the write pointer and advances it. An accepted pop advances the read pointer. One cycle later it raises `pop_valid` with the word that was at the old read pointer. Words leave in the order they were accepted.
- R4: `empty` is 1 exactly when the read and write pointers are equal. A pop request while empty is ignored: no `pop_valid` and no pointer change.
- R5: `full` is 1 when advancing the write pointer would make it equal the read pointer. A push while full is rejected. `push_ok` is 0 in that cycle and the write pointer keeps its value. `push_ok` is 1 in the same cycle as every accepted push. A region of N entries accepts N-1 words.
- R6: `ptr_status` carries the read pointer in bits 8:0 and the write pointer in bits 24:16. All other bits are 0.
- R7: A peek with `peek_en` high and `peek_chan` equal to the channel number (default 0) raises `peek_valid` one cycle later. `peek_data` then holds the word stored at `peek_ptr`. A peek aimed at another channel leaves `peek_valid` low.
- R8: A peek changes neither pointer, nor `empty` or `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_start | input | 9 | First entry of the region |
| cfg_end | input | 9 | Last entry of the region |
| push_valid | input | 1 | Push request |
| push_data | input | 32 | Word to push |
| push_ok | output | 1 | Push accepted this cycle |
| pop_req | input | 1 | Pop request |
| pop_valid | output | 1 | Popped word valid |
| pop_data | output | 32 | Popped word |
| empty | output | 1 | Pointers are equal |
| full | output | 1 | No free slot |
| ptr_status | output | 32 | Read pointer in bits 8:0, write pointer in bits 24:16 |
| peek_en | input | 1 | Peek request |
| peek_chan | input | 4 | Channel the peek is aimed at |
| peek_ptr | input | 9 | Entry to peek |
| peek_valid | output | 1 | Peek word valid |
| peek_data | output | 32 | Peeked word |

## Verification
Three regions are used. The first is an eight-entry region near the top of the array, where both pointers wrap many times. The second is a one-entry region, which is at once empty and full, so every push is refused. The third is a region ending at the last array entry, which tells a wrap to the start bound apart from a natural 9-bit rollover. Each region is run through fill-to-full, drain-to-empty, pushes and pops in the same cycle, and interleaved traffic. These separate the wrong inclusive bound, the wrong full test and a pop that is not gated by empty. Peeks at live entries, with a matching and a non-matching channel, show whether data comes back and whether a peek disturbs the pointers.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  localparam int PTR_W  = 9;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 1 << PTR_W;

  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [DATA_W-1:0] word_t;

  // Next position inside an inclusive [s, e] region.
  function automatic ptr_t ptr_next(ptr_t p, ptr_t s, ptr_t e);
    return (p == e) ? s : p + ptr_t'(1);
  endfunction
endpackage

// File: rtl/cfifo_ptr.sv
module cfifo_ptr
  import cfifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ptr_t lo,
  input  ptr_t hi,
  input  logic step,
  output ptr_t q
);
  ptr_t q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)    q_r <= lo;
    else if (step) q_r <= ptr_next(q_r, lo, hi);
  end

  assign q = q_r;

  a_r2_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    (step && q_r == hi) |=> (q_r == $past(lo)));
  a_r2_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && q_r != hi) |=> (q_r == $past(q_r) + ptr_t'(1)));
endmodule

// File: rtl/cfifo_store.sv
module cfifo_store
  import cfifo_pkg::*;
#(
  parameter int NRD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  ptr_t              wr_addr,
  input  word_t             wr_data,
  input  logic  [NRD-1:0]   rd_en,
  input  ptr_t  [NRD-1:0]   rd_addr,
  output word_t [NRD-1:0]   rd_data,
  output logic  [NRD-1:0]   rd_valid
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n) rd_valid[g] <= 1'b0;
      else        rd_valid[g] <= rd_en[g];
      if (rd_en[g]) rd_data[g] <= mem[rd_addr[g]];
    end

    a_r7_read_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[g] |=> rd_valid[g]);
  end
endmodule

// File: rtl/cfifo_bounded.sv
module cfifo_bounded
  import cfifo_pkg::*;
#(
  parameter int CHAN_W  = 4,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  cfg_start,
  input  logic [PTR_W-1:0]  cfg_end,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ok,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              empty,
  output logic              full,
  output logic [31:0]       ptr_status,
  input  logic              peek_en,
  input  logic [CHAN_W-1:0] peek_chan,
  input  logic [PTR_W-1:0]  peek_ptr,
  output logic              peek_valid,
  output logic [DATA_W-1:0] peek_data
);
  localparam int WR_LSB = 16;
  localparam int RD_PORT = 0;
  localparam int PK_PORT = 1;

  ptr_t rd_q, wr_q, wr_adv;
  logic push_fire, pop_fire, peek_hit;
  logic  [1:0] rd_en_v, rd_valid_v;
  ptr_t  [1:0] rd_addr_v;
  word_t [1:0] rd_data_v;

  assign wr_adv    = ptr_next(wr_q, cfg_start, cfg_end);
  assign empty     = (rd_q == wr_q);
  assign full      = (wr_adv == rd_q);
  assign push_fire = push_valid && !full;
  assign pop_fire  = pop_req && !empty;
  assign peek_hit  = peek_en && (peek_chan == CHAN_W'(CHAN_ID));
  assign push_ok   = push_fire;

  cfifo_ptr u_rd (.clk(clk), .rst_n(rst_n), .lo(cfg_start), .hi(cfg_end),
                  .step(pop_fire), .q(rd_q));
  cfifo_ptr u_wr (.clk(clk), .rst_n(rst_n), .lo(cfg_start), .hi(cfg_end),
                  .step(push_fire), .q(wr_q));

  assign rd_en_v[RD_PORT]   = pop_fire;
  assign rd_addr_v[RD_PORT] = rd_q;
  assign rd_en_v[PK_PORT]   = peek_hit;
  assign rd_addr_v[PK_PORT] = peek_ptr;

  cfifo_store #(.NRD(2)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_fire), .wr_addr(wr_q), .wr_data(push_data),
    .rd_en(rd_en_v), .rd_addr(rd_addr_v),
    .rd_data(rd_data_v), .rd_valid(rd_valid_v)
  );

  assign pop_valid  = rd_valid_v[RD_PORT];
  assign pop_data   = rd_data_v[RD_PORT];
  assign peek_valid = rd_valid_v[PK_PORT];
  assign peek_data  = rd_data_v[PK_PORT];

  always_comb begin
    ptr_status = '0;
    ptr_status[PTR_W-1:0]             = rd_q;
    ptr_status[WR_LSB +: PTR_W]       = wr_q;
  end

  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req) |=> (rd_q == $past(rd_q) && !pop_valid));
  a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid) |=> (wr_q == $past(wr_q)));
  a_r3_pop_gives_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> pop_valid);
  a_r8_peek_holds_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_en && !push_valid && !pop_req) |=> ($stable(rd_q) && $stable(wr_q)));
  a_r7_peek_returns: assert property (@(posedge clk) disable iff (!rst_n)
    peek_hit |=> peek_valid);
  a_r7_peek_other_chan: assert property (@(posedge clk) disable iff (!rst_n)
    !peek_hit |=> !peek_valid);
endmodule

// File: tb/cfifo_bounded_test.sv
module cfifo_bounded_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [8:0]  cfg_start = 0, cfg_end = 0;
  logic        push_valid = 0, pop_req = 0, peek_en = 0;
  logic [31:0] push_data = 0;
  logic [3:0]  peek_chan = 0;
  logic [8:0]  peek_ptr = 0;
  logic        push_ok, pop_valid, empty, full, peek_valid;
  logic [31:0] pop_data, ptr_status, peek_data;

  int checks = 0, failures = 0;
  logic [31:0] sb[$];
  logic [31:0] shadow [512];
  logic [8:0]  m_rd, m_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfifo_bounded uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .push_valid(push_valid), .push_data(push_data), .push_ok(push_ok),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
    .empty(empty), .full(full), .ptr_status(ptr_status),
    .peek_en(peek_en), .peek_chan(peek_chan), .peek_ptr(peek_ptr),
    .peek_valid(peek_valid), .peek_data(peek_data)
  );

  function automatic logic [8:0] wrap_inc(logic [8:0] p);
    if (p == cfg_end) return cfg_start;
    return p + 9'd1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare every popped word with the scoreboard head (R3)
  always @(negedge clk) begin
    if (rst_n && pop_valid) begin
      if (sb.size() == 0) check(0, "R3 pop with empty scoreboard", pop_data, 32'h0);
      else begin
        logic [31:0] e;
        e = sb.pop_front();
        check(pop_data === e, "R3 pop order", pop_data, e);
      end
    end
  end

  task automatic check_state(input string req);
    logic [31:0] exp;
    exp = {7'd0, m_wr, 7'd0, m_rd};
    check(ptr_status === exp, {req, "/R6 ptr_status"}, ptr_status, exp);
    check(empty === (m_rd == m_wr), {req, "/R4 empty"}, 32'(empty), 32'(m_rd == m_wr));
    check(full === (wrap_inc(m_wr) == m_rd), {req, "/R5 full"}, 32'(full),
          32'(wrap_inc(m_wr) == m_rd));
  endtask

  task automatic do_reset(input logic [8:0] s, input logic [8:0] e);
    rst_n = 0; cfg_start = s; cfg_end = e;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_rd = s; m_wr = s; sb.delete();
    #1;
    check_state("R1");
    check(!pop_valid && !peek_valid, "R1 valids low", {pop_valid, peek_valid}, 0);
  endtask

  // Driver: one cycle of push/pop, model update, state compare
  task automatic step(input bit p, input logic [31:0] d, input bit q);
    bit ep, eo;
    push_valid = p; push_data = d; pop_req = q;
    ep = p && (wrap_inc(m_wr) != m_rd);
    eo = q && (m_rd != m_wr);
    #1;
    check(push_ok === ep, "R5 push_ok", 32'(push_ok), 32'(ep));
    if (ep) sb.push_back(d);
    @(negedge clk);
    push_valid = 0; pop_req = 0;
    if (ep) begin shadow[m_wr] = d; m_wr = wrap_inc(m_wr); end
    if (eo) m_rd = wrap_inc(m_rd);
    #1;
    check(pop_valid === eo, "R4/R3 pop_valid", 32'(pop_valid), 32'(eo));
    check_state("R2");
  endtask

  task automatic peek(input logic [3:0] ch, input logic [8:0] ptr);
    bit hit;
    hit = (ch == 4'd0);
    peek_en = 1; peek_chan = ch; peek_ptr = ptr;
    @(negedge clk);
    peek_en = 0;
    #1;
    check(peek_valid === hit, "R7 peek_valid", 32'(peek_valid), 32'(hit));
    if (hit) check(peek_data === shadow[ptr], "R7 peek_data", peek_data, shadow[ptr]);
    check_state("R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Eight-entry region near the top of the array
    do_reset(9'd500, 9'd507);
    step(0, 0, 1);                                    // R4 pop while empty
    for (int i = 0; i < 8; i++) step(1, 32'hA000_0000 + i, 0);  // R5 8th refused
    check(full === 1'b1, "R5 full after 7", 32'(full), 1);
    step(1, 32'hDEAD_0001, 1);                        // R5 push refused while full
    peek(4'd0, 9'd502);                               // R7 live entry
    peek(4'd3, 9'd502);                               // R7 other channel
    peek(4'd0, 9'd506);                               // R8 pointers stay
    for (int i = 0; i < 8; i++) step(0, 0, 1);        // drain, R4 last ignored
    step(1, 32'hB000_0000, 0);
    check(ptr_status[24:16] === 9'd500, "R2 wrap 507->500", 32'(ptr_status[24:16]), 500);
    for (int i = 0; i < 40; i++) step(1, 32'hC000_0000 + i, (i % 3) != 0);
    for (int i = 0; i < 20; i++) step(i < 10, 32'hC100_0000 + i, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    // One-entry region: always empty and full
    do_reset(9'd33, 9'd33);
    step(1, 32'h1111_1111, 0);
    step(1, 32'h2222_2222, 1);
    // Region ending at the last array entry
    do_reset(9'd508, 9'd511);
    for (int i = 0; i < 30; i++) step(1, 32'hE000_0000 + i, (i % 2) == 1);
    peek(4'd0, m_rd);
    for (int i = 0; i < 6; i++) step(0, 0, 1);
    check(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule